// File: doc/BRIEF.md
# UART Interrupt Flag, Enable and Command Register Block

This block is the interrupt and control register slice of a UART. It keeps a small set of interrupt flags that software can write directly, set through an OR alias or clear through an AND-NOT alias. It also keeps an enable mask for those flags and accepts write-one commands that switch the receiver and the transmitter on and off. The serial engines supply event and level inputs. The block combines flags and enables into two interrupt lines: one for receive and one for transmit.

The receiver and the transmitter each have a two-state enable machine with the states `CH_OFF` and `CH_ON`. The transition `CH_OFF -> CH_ON` is taken on an enable command that has no disable command in the same write. The transition `CH_ON -> CH_OFF` is taken on any disable command. Every other case holds the current state. The block also stores a synchronous-mode control bit and the pin-routing fields, and drives them out to the neighbouring logic. Reads are combinational on a 32-bit data port, and writes take effect at the next clock edge.

Top module: `uirq_regs`

## Requirements
- R1: After reset every stored flag, the enable mask, the control bit and the routing fields are zero, both channels are off (status 0x10 reads 0 with all engine inputs low), and both interrupt lines are low.
- R2: Flag bit 1 (transmit buffer room) always equals `tx_room_in`. Writes to the flag register (0x40) and to the clear alias (0x48) do not change it.
- R3: Flag bit 0 sets on a rising edge of `tx_done_in`, bit 2 on a rising edge of `rx_avail_in`, and bit 4 on a rising edge of `rx_ovf_in`. Each stays set after its input falls. An input that is held high does not set the flag again after it is cleared.
- R4: A write to 0x40 loads flag bits 0, 2 and 4 from the data. A write to 0x44 ORs the data into them. A write to 0x48 clears the bits that are one in the data. The result is visible from the next cycle.
- R5: When a rising input edge and a software write or clear hit the same flag in the same cycle, the flag ends up set.
- R6: Command register 0x0C: bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. When enable and disable arrive in the same write, disable wins. Status bit 0 shows the receiver as enabled and status bit 1 shows the transmitter as enabled. The same states drive `rx_enabled` and `tx_enabled`.
- R7: Status register 0x10 reports `tx_done_in` in bit 5, `tx_room_in` in bit 6 and `rx_avail_in` in bit 7.
- R8: Enable register 0x4C stores only bits 0, 1, 2 and 4, and every other bit reads as zero. `irq_rx` is high when flag bit 2 or flag bit 4 is both set and enabled. `irq_tx` is high when flag bit 0 or flag bit 1 is both set and enabled.
- R9: Control register 0x00 bit 0 reads back as written and drives `sync_mode`. Routing register 0x54 stores bit 0 (`route_rx_pen`), bit 1 (`route_tx_pen`) and bits 10:8 (`route_loc`), and every other bit reads as zero.
- R10: The command register, the set alias and the clear alias all read as zero. Any offset that is not mapped reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_done_in | input | 1 | Transmitter idle with nothing left to send (level) |
| tx_room_in | input | 1 | Transmit buffer can take data (level) |
| rx_avail_in | input | 1 | Received data waiting (level) |
| rx_ovf_in | input | 1 | Receive overflow event |
| rx_enabled | output | 1 | Receiver enable state |
| tx_enabled | output | 1 | Transmitter enable state |
| sync_mode | output | 1 | Synchronous mode select |
| route_rx_pen | output | 1 | Receive pin enable |
| route_tx_pen | output | 1 | Transmit pin enable |
| route_loc | output | 3 | Pin location select |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The hardest situation to reach is a rising engine edge that lands in the same cycle as a software clear of that flag. The stimulus reaches it by raising `rx_avail_in` at the falling clock edge in the same half-cycle that the clear write is driven, so both meet at one rising edge. A related case is a level input that stays high after its flag is cleared. The bench covers it by clearing a flag while the input is still held and checking that the flag stays low. Both enable machines are also taken through a write that carries enable and disable together, starting from each state.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    // register byte offsets
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_CMD    = 'h0C;
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_FLAGS  = 'h40;
    localparam int OFS_FSET   = 'h44;
    localparam int OFS_FCLR   = 'h48;
    localparam int OFS_EN     = 'h4C;
    localparam int OFS_ROUTE  = 'h54;

    // flag bit positions
    localparam int FB_TXC  = 0;
    localparam int FB_TXBL = 1;
    localparam int FB_RXV  = 2;
    localparam int FB_RXOF = 4;

    // status bit positions
    localparam int ST_RXON = 0;
    localparam int ST_TXON = 1;
    localparam int ST_TXC  = 5;
    localparam int ST_TXBL = 6;
    localparam int ST_RXV  = 7;

    // routing and control bit positions
    localparam int RT_RXPEN   = 0;
    localparam int RT_TXPEN   = 1;
    localparam int RT_LOC_LSB = 8;
    localparam int CTRL_SYNC  = 0;

    // channel 0 = receiver, channel 1 = transmitter; command bits 2*ch, 2*ch+1
    localparam int N_CHAN = 2;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_ON  = 1'b1
    } chan_state_e;
endpackage

// File: rtl/uirq_chan_fsm.sv
module uirq_chan_fsm
    import uirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    output logic active
);
    chan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: if (en_cmd && !dis_cmd) state_d = CH_ON;
            CH_ON:  if (dis_cmd)            state_d = CH_OFF;
        endcase
    end

    always_comb begin
        active = (state_q == CH_ON);
    end

    a_r6_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
        dis_cmd |=> !active);
    a_r6_en_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmd && !dis_cmd) |=> active);
endmodule

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank
    import uirq_pkg::*;
#(
    parameter int FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] hw_lvl,
    input  logic [FLAG_W-1:0] live_lvl,
    input  logic              wr_direct,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] flags_o
);
    localparam logic [FLAG_W-1:0] STICKY =
        FLAG_W'((1 << FB_TXC) | (1 << FB_RXV) | (1 << FB_RXOF));
    localparam logic [FLAG_W-1:0] LIVE = FLAG_W'(1 << FB_TXBL);

    logic [FLAG_W-1:0] prev_q, sticky_q, sw_next, rise;

    assign rise = hw_lvl & ~prev_q & STICKY;

    always_comb begin
        if (wr_direct)   sw_next = wdata;
        else if (wr_set) sw_next = sticky_q | wdata;
        else if (wr_clr) sw_next = sticky_q & ~wdata;
        else             sw_next = sticky_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            sticky_q <= '0;
        end else begin
            prev_q   <= hw_lvl;
            sticky_q <= (sw_next | rise) & STICKY;
        end
    end

    assign flags_o = sticky_q | (live_lvl & LIVE);

    for (genvar g = 0; g < FLAG_W; g++) begin : g_chk
        if (STICKY[g]) begin : g_sticky
            a_r5_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                rise[g] |=> flags_o[g]);
            a_r4_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_clr && wdata[g] && !rise[g] && !wr_direct && !wr_set) |=> !flags_o[g]);
        end
    end
endmodule

// File: rtl/uirq_regs.sv
module uirq_regs
    import uirq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LOC_W  = 3,
    parameter int FLAG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_done_in,
    input  logic              tx_room_in,
    input  logic              rx_avail_in,
    input  logic              rx_ovf_in,
    output logic              rx_enabled,
    output logic              tx_enabled,
    output logic              sync_mode,
    output logic              route_rx_pen,
    output logic              route_tx_pen,
    output logic [LOC_W-1:0]  route_loc,
    output logic              irq_rx,
    output logic              irq_tx
);
    localparam logic [FLAG_W-1:0] EN_MASK =
        FLAG_W'((1 << FB_TXC) | (1 << FB_TXBL) | (1 << FB_RXV) | (1 << FB_RXOF));
    localparam logic [FLAG_W-1:0] RX_SET = FLAG_W'((1 << FB_RXV) | (1 << FB_RXOF));
    localparam logic [FLAG_W-1:0] TX_SET = FLAG_W'((1 << FB_TXC) | (1 << FB_TXBL));

    logic wr_ctrl, wr_cmd, wr_flags, wr_fset, wr_fclr, wr_en, wr_route;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_cmd   = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
    assign wr_flags = bus_wr && (bus_addr == ADDR_W'(OFS_FLAGS));
    assign wr_fset  = bus_wr && (bus_addr == ADDR_W'(OFS_FSET));
    assign wr_fclr  = bus_wr && (bus_addr == ADDR_W'(OFS_FCLR));
    assign wr_en    = bus_wr && (bus_addr == ADDR_W'(OFS_EN));
    assign wr_route = bus_wr && (bus_addr == ADDR_W'(OFS_ROUTE));

    // stored configuration
    logic              sync_q, rxpen_q, txpen_q;
    logic [LOC_W-1:0]  loc_q;
    logic [FLAG_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 1'b0;
            rxpen_q <= 1'b0;
            txpen_q <= 1'b0;
            loc_q   <= '0;
            en_q    <= '0;
        end else begin
            if (wr_ctrl) sync_q <= bus_wdata[CTRL_SYNC];
            if (wr_route) begin
                rxpen_q <= bus_wdata[RT_RXPEN];
                txpen_q <= bus_wdata[RT_TXPEN];
                loc_q   <= bus_wdata[RT_LOC_LSB +: LOC_W];
            end
            if (wr_en) en_q <= bus_wdata[FLAG_W-1:0] & EN_MASK;
        end
    end

    // receive / transmit enable machines
    logic [N_CHAN-1:0] chan_on;

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        uirq_chan_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_cmd  (wr_cmd && bus_wdata[2*g]),
            .dis_cmd (wr_cmd && bus_wdata[2*g+1]),
            .active  (chan_on[g])
        );
    end

    // interrupt flags
    logic [FLAG_W-1:0] hw_lvl, live_lvl, flags;

    always_comb begin
        hw_lvl           = '0;
        hw_lvl[FB_TXC]   = tx_done_in;
        hw_lvl[FB_RXV]   = rx_avail_in;
        hw_lvl[FB_RXOF]  = rx_ovf_in;
        live_lvl          = '0;
        live_lvl[FB_TXBL] = tx_room_in;
    end

    uirq_flag_bank #(.FLAG_W(FLAG_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_lvl    (hw_lvl),
        .live_lvl  (live_lvl),
        .wr_direct (wr_flags),
        .wr_set    (wr_fset),
        .wr_clr    (wr_fclr),
        .wdata     (bus_wdata[FLAG_W-1:0]),
        .flags_o   (flags)
    );

    // read path
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):   bus_rdata[CTRL_SYNC] = sync_q;
            ADDR_W'(OFS_STATUS): begin
                bus_rdata[ST_RXON] = chan_on[0];
                bus_rdata[ST_TXON] = chan_on[1];
                bus_rdata[ST_TXC]  = tx_done_in;
                bus_rdata[ST_TXBL] = tx_room_in;
                bus_rdata[ST_RXV]  = rx_avail_in;
            end
            ADDR_W'(OFS_FLAGS):  bus_rdata[FLAG_W-1:0] = flags;
            ADDR_W'(OFS_EN):     bus_rdata[FLAG_W-1:0] = en_q;
            ADDR_W'(OFS_ROUTE): begin
                bus_rdata[RT_RXPEN]              = rxpen_q;
                bus_rdata[RT_TXPEN]              = txpen_q;
                bus_rdata[RT_LOC_LSB +: LOC_W]   = loc_q;
            end
            default: ;
        endcase
    end

    // outputs
    assign rx_enabled   = chan_on[0];
    assign tx_enabled   = chan_on[1];
    assign sync_mode    = sync_q;
    assign route_rx_pen = rxpen_q;
    assign route_tx_pen = txpen_q;
    assign route_loc    = loc_q;
    assign irq_rx       = |(flags & en_q & RX_SET);
    assign irq_tx       = |(flags & en_q & TX_SET);

    a_r2_live_level: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_FLAGS)) |-> (bus_rdata[FB_TXBL] == tx_room_in));
endmodule

// File: tb/uirq_regs_test.sv
module uirq_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_done_in = 1'b0, tx_room_in = 1'b0, rx_avail_in = 1'b0, rx_ovf_in = 1'b0;
    logic        rx_enabled, tx_enabled, sync_mode, route_rx_pen, route_tx_pen;
    logic [2:0]  route_loc;
    logic        irq_rx, irq_tx;

    always #5 clk = ~clk;

    uirq_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_done_in(tx_done_in), .tx_room_in(tx_room_in),
        .rx_avail_in(rx_avail_in), .rx_ovf_in(rx_ovf_in),
        .rx_enabled(rx_enabled), .tx_enabled(tx_enabled), .sync_mode(sync_mode),
        .route_rx_pen(route_rx_pen), .route_tx_pen(route_tx_pen),
        .route_loc(route_loc), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [7:0]  caddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } step_t;

    localparam int NSTEP = 15;
    localparam step_t TBL [NSTEP] = '{
        '{1'b1, 8'h4C, 32'hFFFF_FFFF, 8'h4C, 32'h17,  8'd8},  // R8 enable mask
        '{1'b1, 8'h44, 32'h15,        8'h40, 32'h15,  8'd4},  // R4 set alias
        '{1'b1, 8'h48, 32'h04,        8'h40, 32'h11,  8'd4},  // R4 clear alias
        '{1'b1, 8'h40, 32'h06,        8'h40, 32'h04,  8'd2},  // R2/R4 direct, bit1 live
        '{1'b1, 8'h00, 32'h03,        8'h00, 32'h01,  8'd9},  // R9 control
        '{1'b1, 8'h54, 32'hFFFF,      8'h54, 32'h703, 8'd9},  // R9 routing
        '{1'b1, 8'h0C, 32'h05,        8'h10, 32'h03,  8'd6},  // R6 both on
        '{1'b1, 8'h0C, 32'h0A,        8'h10, 32'h00,  8'd6},  // R6 both off
        '{1'b1, 8'h0C, 32'h0F,        8'h10, 32'h00,  8'd6},  // R6 disable wins from off
        '{1'b1, 8'h0C, 32'h04,        8'h10, 32'h02,  8'd6},  // R6 tx only
        '{1'b1, 8'h0C, 32'h01,        8'h0C, 32'h00,  8'd10}, // R10 cmd reads zero
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 8'h20, 32'h00,  8'd10}, // R10 unmapped
        '{1'b0, 8'h00, 32'h00,        8'h44, 32'h00,  8'd10}, // R10 set alias reads zero
        '{1'b1, 8'h0C, 32'h0F,        8'h10, 32'h00,  8'd6},  // R6 disable wins from on
        '{1'b1, 8'h48, 32'h1F,        8'h40, 32'h00,  8'd4}   // R4 clear all
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h40, 32'h0, "R1 flags");
        rd(8'h4C, 32'h0, "R1 enable");
        rd(8'h10, 32'h0, "R1 status");
        rd(8'h00, 32'h0, "R1 control");
        rd(8'h54, 32'h0, "R1 routing");
        chk({30'b0, irq_rx, irq_tx}, 32'h0, "R1 irqs");
        chk({30'b0, rx_enabled, tx_enabled}, 32'h0, "R1 channels");

        // table walk
        for (int i = 0; i < NSTEP; i++) begin
            @(negedge clk);
            bus_wr = TBL[i].wr; bus_addr = TBL[i].addr; bus_wdata = TBL[i].wdata;
            @(posedge clk);
            @(negedge clk);
            bus_wr = 1'b0;
            rd(TBL[i].caddr, TBL[i].exp, $sformatf("R%0d step %0d", TBL[i].req, i));
        end
        rd(8'h48, 32'h0, "R10 clear alias reads zero");
        wr(8'h0C, 32'h05);

        // R9 / R6 outputs
        chk({31'b0, sync_mode}, 32'h1, "R9 sync_mode");
        chk({27'b0, route_loc, route_tx_pen, route_rx_pen}, 32'h1F, "R9 routing outputs");
        chk({30'b0, rx_enabled, tx_enabled}, 32'h3, "R6 channel outputs");

        // R3 tx done rising edge
        @(negedge clk); tx_done_in = 1'b1;
        @(posedge clk); @(negedge clk);
        rd(8'h40, 32'h01, "R3 tx done flag");
        chk({31'b0, irq_tx}, 32'h1, "R8 irq_tx");
        chk({31'b0, irq_rx}, 32'h0, "R8 irq_rx quiet");
        rd(8'h10, 32'h23, "R7 status tx done");
        wr(8'h48, 32'h01);
        @(negedge clk);
        rd(8'h40, 32'h00, "R3 held input no re-set");

        // R2 live level
        tx_room_in = 1'b1;
        rd(8'h40, 32'h02, "R2 live follows");
        chk({31'b0, irq_tx}, 32'h1, "R8 irq_tx from room");
        wr(8'h48, 32'h02);
        rd(8'h40, 32'h02, "R2 clear ignored");
        rd(8'h10, 32'h63, "R7 status room");
        tx_room_in = 1'b0;
        rd(8'h40, 32'h00, "R2 live drops");

        // R5 hardware set beats same-cycle clear
        @(negedge clk);
        rx_avail_in = 1'b1; bus_wr = 1'b1; bus_addr = 8'h48; bus_wdata = 32'h04;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
        rd(8'h40, 32'h04, "R5 hw wins");
        chk({31'b0, irq_rx}, 32'h1, "R8 irq_rx");

        // R3 overflow pulse sticks
        @(negedge clk); rx_ovf_in = 1'b1;
        @(negedge clk); rx_ovf_in = 1'b0;
        @(negedge clk);
        rd(8'h40, 32'h14, "R3 overflow sticky");
        wr(8'h48, 32'h04);
        rd(8'h40, 32'h10, "R3 rx flag cleared while held");

        // R8 masking
        wr(8'h4C, 32'h00);
        #1;
        chk({30'b0, irq_rx, irq_tx}, 32'h0, "R8 masked");
        wr(8'h4C, 32'h10);
        #1;
        chk({30'b0, irq_rx, irq_tx}, 32'h2, "R8 overflow enabled");

        // R7 all status levels
        rd(8'h10, 32'hA3, "R7 status levels");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule